// File: doc/BRIEF.md
# Parallel EPROM Read Sequencer

This block sits on the host side of an asynchronous 8K x 8 parallel read-only memory that has separate chip-select and output-gate lines, both active low. A client presents a 13-bit address with a request while the block shows ready. The block latches the address and drives it to the memory. It pulls the chip select low at once and pulls the output gate low a fixed number of cycles later. It then waits until the address, chip-select and output-gate delays have all been met, captures the byte, and returns it with a one-cycle valid strobe.

In the same cycle as the capture, both enables are released, so the memory goes back to standby. The block then waits out the output float time before it shows ready again. This keeps a later access, or any other device on the same bus, from driving data while the memory outputs are still active.

Every delay is given in nanoseconds and turned into a cycle count by rounding up against the clock period parameter. The access wait is the largest of three figures: the address delay, the chip-select delay, and the output-gate lag plus the output-gate delay. With the defaults (10 ns clock, 200/200/100/50 ns, lag 5) the access wait is 20 cycles and the float wait is 5 cycles.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, ready is 1, mem_ce_n is 1, mem_oe_n is 1 and rd_valid is 0. Reset during an access abandons the access.
- R2: A request is taken only on a clock edge where req and ready are both 1. From the next cycle, mem_addr equals the requested address, mem_ce_n is 0 and ready is 0.
- R3: mem_oe_n goes low exactly OE_LAG_CYC cycles after mem_ce_n goes low, and it is never low while mem_ce_n is high.
- R4: The byte on mem_dq is captured on the edge that comes WAIT cycles after the accept edge. WAIT is the largest of ceil(T_ACC/CLK), ceil(T_CE/CLK) and OE_LAG_CYC + ceil(T_OE/CLK). rd_valid is 1 for exactly the one cycle that follows that edge, and rd_data carries the captured byte.
- R5: In the cycle where rd_valid is 1, mem_ce_n and mem_oe_n are both already high.
- R6: After the capture edge, ready stays 0 and mem_ce_n stays 1 for FLOAT = max(1, ceil(T_OFF/CLK)) cycles. ready returns to 1 in the cycle after that.
- R7: req and req_addr are ignored while ready is 0. No new access starts, and mem_addr does not change.
- R8: The access counter and the float counter never pass their own last value.
- R9: mem_addr is stable in every cycle in which mem_ce_n stays low.
- R10: rd_data keeps the last captured byte until the next capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Read request, taken when ready is 1 |
| req_addr | input | 13 | Byte address for the request |
| ready | output | 1 | Idle and able to take a request |
| rd_data | output | 8 | Last captured byte |
| rd_valid | output | 1 | One-cycle strobe for a new rd_data |
| mem_addr | output | 13 | Address to the memory |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output gate, active low |
| mem_dq | input | 8 | Data from the memory |

## Verification
A counter that is one step off in the access phase moves the rd_valid pulse by a cycle. It can also make the block capture a byte the bench memory is not yet driving as valid, so the wrong value shows in rd_data within WAIT+1 cycles of the accept. A fault in the output-gate lag shows as mem_oe_n falling on the wrong cycle, and it can also starve the output-gate delay and corrupt the captured byte. A fault in the float phase shows as ready returning early or late, or as a fresh chip select while the bus is still settling, within WAIT+FLOAT+1 cycles.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } rd_state_t;

  // Round a delay in ns up to whole clock cycles.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per_ns);
    return (ns + per_ns - 1) / per_ns;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Cycles from the chip-select edge to the capture edge.
  function automatic int unsigned access_cycles(input int unsigned acc_ns,
                                                input int unsigned ce_ns,
                                                input int unsigned oe_ns,
                                                input int unsigned oe_lag,
                                                input int unsigned per_ns);
    int unsigned w;
    w = max2(ns_to_cyc(acc_ns, per_ns), ns_to_cyc(ce_ns, per_ns));
    w = max2(w, oe_lag + ns_to_cyc(oe_ns, per_ns));
    return max2(w, 1);
  endfunction

  // Cycles the bus is left to float after the enables are released.
  function automatic int unsigned float_cycles(input int unsigned off_ns, input int unsigned per_ns);
    return max2(ns_to_cyc(off_ns, per_ns), 1);
  endfunction

endpackage

// File: rtl/eprom_rd_timer.sv
module eprom_rd_timer #(
  parameter int          CNT_W = 5,
  parameter int unsigned LAST  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);

  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LAST);

  assign hit = run && (cnt == LAST_V);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || hit) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_V); // R8

endmodule

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
  import eprom_rd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req,
  input  logic      acc_hit,
  input  logic      flt_hit,
  output rd_state_t state,
  output logic      accept,
  output logic      capture
);

  rd_state_t state_nx;

  assign accept  = (state == ST_IDLE) && req;
  assign capture = (state == ST_ACCESS) && acc_hit;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (req)     state_nx = ST_ACCESS;
      ST_ACCESS: if (acc_hit) state_nx = ST_FLOAT;
      ST_FLOAT:  if (flt_hit) state_nx = ST_IDLE;
      default:                state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  AST_FLOAT_NOT_TO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FLOAT) |=> (state != ST_ACCESS)); // R6

  AST_ACCESS_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_ACCESS) |-> $past(accept)); // R2

endmodule

// File: rtl/eprom_rd_capture.sv
module eprom_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              valid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= capture;
      if (capture) dout <= din;
    end
  end

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && $past(rst_n)) |=> $stable(dout)); // R10

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int          ADDR_W     = 13,
  parameter int          DATA_W     = 8,
  parameter int unsigned CLK_NS     = 10,
  parameter int unsigned T_ACC_NS   = 200,
  parameter int unsigned T_CE_NS    = 200,
  parameter int unsigned T_OE_NS    = 100,
  parameter int unsigned T_OFF_NS   = 50,
  parameter int unsigned OE_LAG_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_dq
);

  localparam int unsigned WAIT_CYC  = access_cycles(T_ACC_NS, T_CE_NS, T_OE_NS, OE_LAG_CYC, CLK_NS);
  localparam int unsigned FLOAT_CYC = float_cycles(T_OFF_NS, CLK_NS);
  localparam int          CNT_W     = $clog2(max2(max2(WAIT_CYC, FLOAT_CYC), OE_LAG_CYC) + 1);
  localparam logic [CNT_W-1:0] LAG_V = CNT_W'(OE_LAG_CYC);

  rd_state_t         state;
  logic              accept, capture;
  logic              acc_run, flt_run, acc_hit, flt_hit;
  logic [CNT_W-1:0]  acc_cnt, flt_cnt;
  logic [ADDR_W-1:0] addr_q;

  eprom_rd_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .acc_hit (acc_hit),
    .flt_hit (flt_hit),
    .state   (state),
    .accept  (accept),
    .capture (capture)
  );

  assign acc_run = (state == ST_ACCESS);
  assign flt_run = (state == ST_FLOAT);

  eprom_rd_timer #(.CNT_W(CNT_W), .LAST(WAIT_CYC - 1)) u_acc_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (acc_run),
    .cnt   (acc_cnt),
    .hit   (acc_hit)
  );

  eprom_rd_timer #(.CNT_W(CNT_W), .LAST(FLOAT_CYC - 1)) u_flt_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (flt_run),
    .cnt   (flt_cnt),
    .hit   (flt_hit)
  );

  eprom_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .din     (mem_dq),
    .dout    (rd_data),
    .valid   (rd_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  assign ready    = (state == ST_IDLE);
  assign mem_addr = addr_q;
  assign mem_ce_n = !acc_run;
  assign mem_oe_n = !(acc_run && (acc_cnt >= LAG_V));

  AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n); // R3

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R4

  AST_ENABLES_OFF_AT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (mem_ce_n && mem_oe_n)); // R5

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n) && $past(rst_n)) |-> $stable(mem_addr)); // R9

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(rst_n)) |=> $stable(mem_addr)); // R7

  AST_READY_IN_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_ce_n && mem_oe_n)); // R6

endmodule

// File: tb/tb_eprom_rd_ctrl.sv
module tb_eprom_rd_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int T_ACC = 200;
  localparam int T_CE  = 200;
  localparam int T_OE  = 100;
  localparam int T_OFF = 50;
  localparam int LAG   = 5;
  localparam int NVEC  = 6;

  localparam logic [12:0] VEC_ADDR [NVEC] = '{13'h0000, 13'h1FFF, 13'h0AAA, 13'h1555, 13'h0123, 13'h1F00};
  localparam logic [7:0]  VEC_DATA [NVEC] = '{8'h05, 8'h02, 8'hFF, 8'hF8, 8'h2E, 8'hFD};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [12:0] req_addr = '0;
  logic ready, rd_valid, mem_ce_n, mem_oe_n;
  logic [7:0] rd_data;
  logic [12:0] mem_addr;
  logic [7:0] mem_dq = 8'h5A;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int w_exp, f_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  eprom_rd_ctrl #(
    .CLK_NS(CLK_PERIOD), .T_ACC_NS(T_ACC), .T_CE_NS(T_CE),
    .T_OE_NS(T_OE), .T_OFF_NS(T_OFF), .OE_LAG_CYC(LAG)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
    .ready(ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_dq(mem_dq)
  );

  function automatic logic [7:0] mem_byte(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  function automatic int cycles_for(input int ns);
    int n = 0;
    while (n * CLK_PERIOD < ns) n++;
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One access: request at a negedge, then walk negedge by negedge.
  task automatic run_access(input logic [12:0] a, input logic [7:0] exp, input bit hold);
    int oe_first = 0;
    int ce_fall = 0;
    @(negedge clk);
    chk(ready === 1'b1, "R2 ready before request", ready, 1);
    req = 1'b1;
    req_addr = a;
    for (int i = 1; i <= w_exp + f_exp + 1; i++) begin
      @(negedge clk);
      if (!hold) req = 1'b0;
      else req_addr = ~a;
      if (i == 1) chk(mem_addr === a, "R2 address driven", mem_addr, a);
      if (i <= w_exp) begin
        chk(mem_ce_n === 1'b0, "R2 chip select low", mem_ce_n, 0);
        chk(ready === 1'b0, "R7 busy", ready, 0);
        chk(mem_addr === a, "R9 address stable", mem_addr, a);
      end else begin
        chk(mem_ce_n === 1'b1, "R6 chip select high after capture", mem_ce_n, 1);
      end
      chk(mem_oe_n === ((i >= LAG + 1 && i <= w_exp) ? 1'b0 : 1'b1), "R3 output gate timing",
          mem_oe_n, (i >= LAG + 1 && i <= w_exp) ? 0 : 1);
      if (mem_oe_n === 1'b0 && oe_first == 0) oe_first = i;
      if (mem_ce_n === 1'b0 && ce_fall == 0) ce_fall = i;
      chk(rd_valid === (i == w_exp + 1), "R4 valid strobe cycle", rd_valid, i == w_exp + 1);
      if (i == w_exp + 1) begin
        chk(rd_data === exp, "R4 captured byte", rd_data, exp);
        chk(mem_ce_n === 1'b1 && mem_oe_n === 1'b1, "R5 enables off at valid",
            {mem_ce_n, mem_oe_n}, 3);
      end
      if (i > w_exp + 1) chk(rd_data === exp, "R10 data held", rd_data, exp);
      chk(ready === (i == w_exp + f_exp + 1), "R6 ready after float", ready, i == w_exp + f_exp + 1);
      if (hold && i > w_exp) chk(mem_addr === a, "R7 held request ignored", mem_addr, a);
      // Memory model for the coming edge: valid only once every delay has run.
      if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 && mem_addr === a &&
          (i - ce_fall + 1) * CLK_PERIOD >= T_CE && (i - ce_fall + 1) * CLK_PERIOD >= T_ACC &&
          (i - oe_first + 1) * CLK_PERIOD >= T_OE)
        mem_dq = mem_byte(a);
      else if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0)
        mem_dq = ~mem_byte(a);
      else
        mem_dq = 8'h5A;
      if (hold && i == w_exp + f_exp) req = 1'b0;
    end
  endtask

  initial begin
    w_exp = cycles_for(T_ACC);
    if (cycles_for(T_CE) > w_exp) w_exp = cycles_for(T_CE);
    if (LAG + cycles_for(T_OE) > w_exp) w_exp = LAG + cycles_for(T_OE);
    f_exp = cycles_for(T_OFF);
    if (f_exp < 1) f_exp = 1;

    repeat (3) @(negedge clk);
    chk(ready === 1'b1 && mem_ce_n === 1'b1 && mem_oe_n === 1'b1 && rd_valid === 1'b0,
        "R1 state in reset", {ready, mem_ce_n, mem_oe_n, rd_valid}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready === 1'b1 && mem_ce_n === 1'b1 && rd_valid === 1'b0,
        "R1 state after reset", {ready, mem_ce_n, rd_valid}, 3'b110);

    for (int v = 0; v < NVEC; v++) run_access(VEC_ADDR[v], VEC_DATA[v], 1'b0);

    // Request held high with a changing address while busy.
    run_access(13'h0777, mem_byte(13'h0777), 1'b1);

    // Reset in the middle of an access.
    @(negedge clk);
    req = 1'b1;
    req_addr = 13'h0042;
    @(negedge clk);
    req = 1'b0;
    repeat (4) @(negedge clk);
    chk(mem_ce_n === 1'b0, "R2 access under way before reset", mem_ce_n, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(mem_ce_n === 1'b1 && mem_oe_n === 1'b1 && ready === 1'b1 && rd_valid === 1'b0,
        "R1 reset abandons access", {mem_ce_n, mem_oe_n, ready, rd_valid}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    run_access(13'h0042, mem_byte(13'h0042), 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    done = 1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule